// File: doc/BRIEF.md
# Load/Store Data Lane Aligner

This block sits between a processor core's load/store unit and a 32-bit data bus, and handles single-register transfers. The core hands over one request at a time on a valid/ready handshake. Each request carries the direction, the access size, a sign flag, the byte address, the store data and the current program counter. The block issues the request on the bus as a non-sequential access. For stores, the narrow data is copied across every byte lane the bus might sample.

For loads, the bus returns narrow data right-justified in the low lanes. The block first copies that data across the word. It then rotates the word right by eight times the low two address bits. After that it masks the result to the access size and, when asked, sign-extends it. A misaligned word load therefore gives a rotated word rather than an error. Every load is followed by exactly one internal idle cycle, flagged on the bus with the captured program counter as its address. The load value is offered to the core only once that idle cycle is over.

The block also keeps the access-type indicator that the next bus user inherits. A request clears it. A completed load sets it, and a completed store clears it again.

Top module: `ldst_lane_aligner`

## Requirements
- R1: After reset, req_ready_o is 1, and rsp_valid_o, bus_req_o, bus_idle_o and seq_o are all 0.
- R2: Access size is encoded as 0 = byte, 1 = halfword, 2 or 3 = word. An unsigned byte load returns bus_rdata_i[7:0] zero-extended, for every value of address bits 1:0.
- R3: An unsigned halfword load returns bus_rdata_i[15:0] zero-extended when address bit 0 is 0. When address bit 0 is 1, it returns the two bytes of that halfword swapped, zero-extended.
- R4: A word load returns bus_rdata_i rotated right by 8 × address bits 1:0. The sign flag has no effect on a word load.
- R5: A signed byte load copies result bit 7 into bits 31:8. A signed halfword load copies result bit 15 into bits 31:16.
- R6: During a store, bus_wdata_o holds four copies of data bits 7:0 for a byte, two copies of bits 15:0 for a halfword, and the data unchanged for a word. bus_addr_o and bus_we_o reflect the request.
- R7: bus_seq_o is 0 in every cycle in which bus_req_o is 1. After a load completes, seq_o is 1 until the next request is accepted. After a store completes, seq_o is 0.
- R8: The cycle after a load's bus acknowledge, bus_idle_o is 1 for exactly one cycle, with idle_addr_o equal to the pc_i captured when the request was accepted. A store produces no idle cycle.
- R9: A load's rsp_valid_o first rises in the cycle after its idle cycle. A store's rsp_valid_o rises in the cycle after its bus acknowledge.
- R10: rsp_valid_o and rsp_rdata_o hold steady until rsp_ready_i is taken. req_ready_o is 0 from acceptance until the response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_signed_i | input | 1 | Sign-extend narrow load |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Store data, right-justified |
| pc_i | input | 32 | Program counter of the issuing instruction |
| rsp_valid_o | output | 1 | Response ready for core |
| rsp_ready_i | input | 1 | Core takes response |
| rsp_rdata_o | output | 32 | Aligned load value |
| seq_o | output | 1 | Access-type indicator for the next bus user |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | Bus write enable |
| bus_addr_o | output | 32 | Bus address |
| bus_size_o | output | 2 | Bus access size |
| bus_seq_o | output | 1 | Sequential marker on the bus access |
| bus_wdata_o | output | 32 | Lane-replicated store data |
| bus_ack_i | input | 1 | Bus access done; read data valid |
| bus_rdata_i | input | 32 | Read data, narrow data in low lanes |
| bus_idle_o | output | 1 | Internal idle cycle |
| idle_addr_o | output | 32 | Address reported with the idle cycle |

## Verification
The hardest conditions to create from the ports are a response held back by the core while the idle cycle and indicator state must stay put, and a bus acknowledge delayed by several cycles. The stimulus covers both: it varies the bus acknowledge latency and withholds rsp_ready_i on alternate transactions. It sweeps every size, both sign settings, all four address offsets and bus words chosen so that each sign bit appears both set and clear. In every sweep point the idle cycle and the rising edge of the response are located cycle by cycle.

// File: rtl/ldst_align_pkg.sv
package ldst_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_BUS  = 2'd1,
    ST_IDLE = 2'd2,
    ST_RESP = 2'd3
  } seq_state_e;
endpackage

// File: rtl/ldst_store_lanes.sv
module ldst_store_lanes
  import ldst_align_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o
);
  localparam int NL = DW / 8;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    always_comb begin
      unique case (acc_size_e'(size_i))
        SZ_BYTE: data_o[8*i +: 8] = data_i[7:0];
        SZ_HALF: data_o[8*i +: 8] = data_i[8*(i%2) +: 8];
        default: data_o[8*i +: 8] = data_i[8*i +: 8];
      endcase
    end
  end
endmodule

// File: rtl/ldst_load_align.sv
module ldst_load_align
  import ldst_align_pkg::*;
#(
  parameter int DW = 32,
  localparam int NL = DW / 8,
  localparam int OW = $clog2(NL)
) (
  input  logic [DW-1:0] raw_i,
  input  logic [OW-1:0] off_i,
  input  logic [1:0]    size_i,
  input  logic          signed_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] rep;
  logic [DW-1:0] rot;

  // narrow data copied across lanes before rotation
  ldst_store_lanes #(.DW(DW)) u_rep (
    .size_i (size_i),
    .data_i (raw_i),
    .data_o (rep)
  );

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      logic [OW-1:0] src;
      src = off_i + OW'(i);
      rot[8*i +: 8] = rep[8*src +: 8];
    end
  end

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: data_o = {{(DW-8){signed_i & rot[7]}}, rot[7:0]};
      SZ_HALF: data_o = {{(DW-16){signed_i & rot[15]}}, rot[15:0]};
      default: data_o = rot;
    endcase
  end
endmodule

// File: rtl/ldst_seq_ctrl.sv
module ldst_seq_ctrl
  import ldst_align_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [1:0]    req_size_i,
  input  logic          req_signed_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [AW-1:0] pc_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          seq_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_size_o,
  output logic          bus_seq_o,
  output logic [DW-1:0] wdata_o,
  output logic          signed_o,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] aligned_i,
  output logic          bus_idle_o,
  output logic [AW-1:0] idle_addr_o
);
  seq_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, pc_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic [1:0]    size_q;
  logic          we_q, sgn_q, seq_q;
  logic          accept, done;

  assign accept = (state_q == ST_WAIT) && req_valid_i;
  assign done   = (state_q == ST_BUS) && bus_ack_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT: if (req_valid_i) state_d = ST_BUS;
      ST_BUS:  if (bus_ack_i)   state_d = we_q ? ST_RESP : ST_IDLE;
      ST_IDLE: state_d = ST_RESP;
      ST_RESP: if (rsp_ready_i) state_d = ST_WAIT;
      default: state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      addr_q  <= '0;
      pc_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      size_q  <= '0;
      we_q    <= 1'b0;
      sgn_q   <= 1'b0;
      seq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= req_addr_i;
        pc_q    <= pc_i;
        wdata_q <= req_wdata_i;
        size_q  <= req_size_i;
        we_q    <= req_write_i;
        sgn_q   <= req_signed_i;
        seq_q   <= 1'b0;
      end
      if (done) begin
        // a load leaves the indicator sequential, a store clears it again
        seq_q <= !we_q;
        if (!we_q) rdata_q <= aligned_i;
      end
    end
  end

  assign req_ready_o = (state_q == ST_WAIT);
  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_rdata_o = rdata_q;
  assign seq_o       = seq_q;
  assign bus_req_o   = (state_q == ST_BUS);
  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_size_o  = size_q;
  assign bus_seq_o   = seq_q;
  assign wdata_o     = wdata_q;
  assign signed_o    = sgn_q;
  assign bus_idle_o  = (state_q == ST_IDLE);
  assign idle_addr_o = pc_q;

  AST_BUS_NONSEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !bus_seq_o); // R7
  AST_STORE_CLEARS_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_ack_i && bus_we_o) |=> !seq_o); // R7
  AST_IDLE_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_ack_i && !bus_we_o) |=> bus_idle_o); // R8
  AST_STORE_NO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_ack_i && bus_we_o) |=> (!bus_idle_o && rsp_valid_o)); // R9
  AST_IDLE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_idle_o |=> (!bus_idle_o && rsp_valid_o)); // R9
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_rdata_o))); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o || bus_idle_o || rsp_valid_o) |-> !req_ready_o); // R10
endmodule

// File: rtl/ldst_lane_aligner.sv
module ldst_lane_aligner
  import ldst_align_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [1:0]    req_size_i,
  input  logic          req_signed_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [AW-1:0] pc_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          seq_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_size_o,
  output logic          bus_seq_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          bus_idle_o,
  output logic [AW-1:0] idle_addr_o
);
  localparam int NL = DW / 8;
  localparam int OW = $clog2(NL);

  logic [DW-1:0] wdata_raw, aligned;
  logic          sgn;

  ldst_seq_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_write_i  (req_write_i),
    .req_size_i   (req_size_i),
    .req_signed_i (req_signed_i),
    .req_addr_i   (req_addr_i),
    .req_wdata_i  (req_wdata_i),
    .pc_i         (pc_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_ready_i  (rsp_ready_i),
    .rsp_rdata_o  (rsp_rdata_o),
    .seq_o        (seq_o),
    .bus_req_o    (bus_req_o),
    .bus_we_o     (bus_we_o),
    .bus_addr_o   (bus_addr_o),
    .bus_size_o   (bus_size_o),
    .bus_seq_o    (bus_seq_o),
    .wdata_o      (wdata_raw),
    .signed_o     (sgn),
    .bus_ack_i    (bus_ack_i),
    .aligned_i    (aligned),
    .bus_idle_o   (bus_idle_o),
    .idle_addr_o  (idle_addr_o)
  );

  ldst_store_lanes #(.DW(DW)) u_store (
    .size_i (bus_size_o),
    .data_i (wdata_raw),
    .data_o (bus_wdata_o)
  );

  ldst_load_align #(.DW(DW)) u_load (
    .raw_i    (bus_rdata_i),
    .off_i    (bus_addr_o[OW-1:0]),
    .size_i   (bus_size_o),
    .signed_i (sgn),
    .data_o   (aligned)
  );
endmodule

// File: tb/ldst_lane_aligner_bench.sv
`timescale 1ns/1ps
module ldst_lane_aligner_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0, pc = '0;
  logic        rsp_ready = 1'b0, bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        req_ready, rsp_valid, seq, bus_req, bus_we, bus_seq, bus_idle;
  logic [31:0] rsp_rdata, bus_addr, bus_wdata, idle_addr;
  logic [1:0]  bus_size;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ldst_lane_aligner u_ldst_lane_aligner (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_size_i(req_size), .req_signed_i(req_signed), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .pc_i(pc),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .seq_o(seq), .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_size_o(bus_size), .bus_seq_o(bus_seq), .bus_wdata_o(bus_wdata),
    .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
    .bus_idle_o(bus_idle), .idle_addr_o(idle_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_load(input logic [1:0] sz, input logic sg,
                                           input logic [1:0] off, input logic [31:0] raw);
    logic [63:0] dbl;
    logic [15:0] h;
    case (sz)
      2'd0: return sg ? {{24{raw[7]}}, raw[7:0]} : {24'd0, raw[7:0]};
      2'd1: begin
        h = off[0] ? {raw[7:0], raw[15:8]} : raw[15:0];
        return sg ? {{16{h[15]}}, h} : {16'd0, h};
      end
      default: begin
        dbl = {raw, raw} >> (8 * off);
        return dbl[31:0];
      end
    endcase
  endfunction

  function automatic logic [31:0] exp_store(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'd0: return {4{d[7:0]}};
      2'd1: return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  task automatic txn(input logic wr, input logic [1:0] sz, input logic sg,
                     input logic [31:0] addr, input logic [31:0] data,
                     input int lat, input bit hold);
    logic [31:0] my_pc;
    my_pc = 32'h0800_0100 + (addr << 2);
    @(negedge clk);
    chk("R10 ready idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_signed = sg;
    req_addr = addr; req_wdata = data; pc = my_pc;
    @(negedge clk);
    req_valid = 1'b0; pc = 32'hDEAD_BEEF; req_wdata = ~data;
    for (int i = 0; i <= lat; i++) begin
      chk("R7 bus req nonseq", {30'd0, bus_req, bus_seq}, 32'd2);
      chk("R10 busy", {30'd0, req_ready, rsp_valid}, 32'd0);
      if (i < lat) @(negedge clk);
    end
    chk("R6 addr/we", bus_addr ^ {31'd0, bus_we}, addr ^ {31'd0, wr});
    if (wr) chk("R6 store lanes", bus_wdata, exp_store(sz, data));
    bus_ack = 1'b1; bus_rdata = data;
    @(negedge clk);
    bus_ack = 1'b0; bus_rdata = 32'h5A5A_A5A5;
    if (!wr) begin
      chk("R8 idle cycle", {31'd0, bus_idle}, 32'd1);
      chk("R8 idle addr", idle_addr, my_pc);
      chk("R9 no rsp during idle", {31'd0, rsp_valid}, 32'd0);
      chk("R7 seq after load", {31'd0, seq}, 32'd1);
      @(negedge clk);
    end
    chk("R9 rsp valid", {31'd0, rsp_valid}, 32'd1);
    chk("R8 single idle", {31'd0, bus_idle}, 32'd0);
    if (wr) chk("R7 seq after store", {31'd0, seq}, 32'd0);
    else begin
      case (sz)
        2'd0: chk(sg ? "R5 byte signed" : "R2 byte", rsp_rdata, exp_load(sz, sg, addr[1:0], data));
        2'd1: chk(sg ? "R5 half signed" : "R3 half", rsp_rdata, exp_load(sz, sg, addr[1:0], data));
        default: chk("R4 word rotate", rsp_rdata, exp_load(sz, sg, addr[1:0], data));
      endcase
    end
    if (hold) begin
      @(negedge clk);
      chk("R10 rsp held", {31'd0, rsp_valid}, 32'd1);
      if (!wr) chk("R10 data held", rsp_rdata, exp_load(sz, sg, addr[1:0], data));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R10 rsp taken", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    automatic logic [31:0] pats[4] = '{32'hF1E2_D3C4, 32'h1234_5678, 32'hA55A_7F80, 32'h4321_8C3D};
    automatic int k = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {27'd0, req_ready, rsp_valid, bus_req, bus_idle, seq}, 32'h10);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {27'd0, req_ready, rsp_valid, bus_req, bus_idle, seq}, 32'h10);
    for (int sz = 0; sz < 4; sz++)
      for (int sg = 0; sg < 2; sg++)
        for (int off = 0; off < 4; off++)
          for (int p = 0; p < 4; p++) begin
            txn(1'b0, 2'(sz), 1'(sg), 32'h0300_0040 + 32'(off) + 32'(p*16),
                pats[p], k % 3, k[0]);
            k++;
          end
    for (int sz = 0; sz < 3; sz++)
      for (int off = 0; off < 4; off++)
        for (int p = 0; p < 4; p++) begin
          txn(1'b1, 2'(sz), 1'b0, 32'h0200_0080 + 32'(off) + 32'(p*8),
              pats[p], k % 4, k[1]);
          k++;
        end
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule